// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the sleep states of a small microcontroller core. Software writes a two-bit mode value: one bit asks for idle and the other for power-down. In idle, only the CPU clock stops. Timers, the serial port, the interrupt logic and RAM keep their clocks. In power-down, the oscillator enable is removed, so every clock stops. The block decides when the CPU clock may run again. It also asserts the register-file reset and blocks RAM writes, so that RAM keeps its contents across a reset.

An enabled interrupt ends idle. Power-down ignores interrupts and ends only on the hardware reset pin. If the hardware reset arrives while the core is idle, the CPU runs on for a grace window of two machine cycles before the internal reset takes over. During that window RAM writes are blocked but port writes are not. The oscillator may have been stopped. The register reset is therefore held for a parameterised start-up count before the CPU clock restarts. A separate active-low power-on input initialises the state registers.

Top module: `lpc_power_ctrl`

## Requirements
- R1: After power-on, and on every reset phase, the outputs read `sfr_reset`=1, `cpu_clk_en`=0, `osc_en`=1, `periph_clk_en`=1 and `mode_bits`=00. With `hw_reset` low, `cpu_clk_en` returns to 1 exactly STARTUP_CYCLES cycles after `por_n` is released.
- R2: A mode write in run state with bit 0 set and bit 1 clear enters idle. From the next cycle, `cpu_clk_en`=0, `periph_clk_en`=1 and `osc_en`=1, and `mode_bits` reads 01.
- R3: A mode write in run state with bit 1 set enters power-down, even when bit 0 is also set. From the next cycle, `cpu_clk_en`, `periph_clk_en` and `osc_en` are all 0, and `mode_bits` reads back the written value. `cpu_clk_en` is never 1 while `osc_en` is 0.
- R4: In idle, any `irq_req` bit whose matching `irq_en` bit is set returns the block to run state at the next clock, with `mode_bits` cleared to 00. Requests whose enable bit is 0 have no effect.
- R5: In power-down, interrupt requests have no effect, whether enabled or not. Only `hw_reset` leaves power-down.
- R6: When `hw_reset` is seen in idle, the CPU runs for 2×MC_CLKS cycles with `cpu_clk_en`=1, `ram_wr_inhibit`=1 and `sfr_reset`=0. The reset phase then begins.
- R7: `ram_wr_inhibit` is 1 for the whole reset phase and 0 in run state. A reset phase that follows the grace window lasts STARTUP_CYCLES cycles when `hw_reset` is already low.
- R8: Leaving power-down by reset, `osc_en` is 1 in the first cycle after `hw_reset` is sampled. `cpu_clk_en` stays 0 for STARTUP_CYCLES cycles counted from that cycle, provided `hw_reset` is released in that first cycle.
- R9: Mode writes are ignored outside run state. In run state, `hw_reset` takes precedence over a mode write made in the same cycle.
- R10: While `hw_reset` stays high, the reset phase continues. Once the start-up count has elapsed, `cpu_clk_en` rises one cycle after `hw_reset` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on initialisation, active low, asynchronous |
| hw_reset | input | 1 | Hardware reset pin, active high, sampled on the clock |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Written mode: bit 0 idle, bit 1 power-down |
| irq_req | input | NIRQ | Pending interrupt sources |
| irq_en | input | NIRQ | Per-source interrupt enables |
| mode_bits | output | 2 | Read-back of the mode register |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| sfr_reset | output | 1 | Register-file reset |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes |

## Verification
The bench builds the block with MC_CLKS=4, STARTUP_CYCLES=10 and NIRQ=5. With these values the grace window is 8 cycles and the start-up hold is 10 cycles, so each can be counted edge by edge. A run where `hw_reset` is held for three times the start-up count also fits in a short test. This makes it possible to check that the timer saturates rather than wraps, and to check exact window lengths for the power-on, power-down and idle reset paths.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_PDOWN = 3'd2,
    ST_GRACE = 3'd3,
    ST_RESET = 3'd4
  } lpc_state_e;

  typedef struct packed {
    logic cpu;
    logic periph;
    logic osc;
    logic sfr_rst;
    logic ram_inh;
  } lpc_outs_t;

  localparam int MODE_IDLE_BIT = 0;
  localparam int MODE_PD_BIT   = 1;

  // Length of the post-idle grace window: two machine cycles.
  function automatic int grace_cycles(input int mc_clks);
    return 2 * mc_clks;
  endfunction

  // Counter width able to hold the larger of two window lengths.
  function automatic int timer_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return $clog2(m + 1);
  endfunction

  // Clock, reset and inhibit levels for each state.
  function automatic lpc_outs_t decode_outputs(input lpc_state_e s);
    lpc_outs_t o;
    case (s)
      ST_RUN:   o = '{cpu: 1'b1, periph: 1'b1, osc: 1'b1, sfr_rst: 1'b0, ram_inh: 1'b0};
      ST_IDLE:  o = '{cpu: 1'b0, periph: 1'b1, osc: 1'b1, sfr_rst: 1'b0, ram_inh: 1'b0};
      ST_PDOWN: o = '{cpu: 1'b0, periph: 1'b0, osc: 1'b0, sfr_rst: 1'b0, ram_inh: 1'b0};
      ST_GRACE: o = '{cpu: 1'b1, periph: 1'b1, osc: 1'b1, sfr_rst: 1'b0, ram_inh: 1'b1};
      default:  o = '{cpu: 1'b0, periph: 1'b1, osc: 1'b1, sfr_rst: 1'b1, ram_inh: 1'b1};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/lpc_wake_detect.sv
module lpc_wake_detect #(
  parameter int NIRQ = 5
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  output logic            wake
);

  logic [NIRQ-1:0] masked;

  for (genvar i = 0; i < NIRQ; i++) begin : g_mask
    assign masked[i] = irq_req[i] & irq_en[i];
  end

  assign wake = |masked;

  // R4: a source whose enable is clear never raises a wake.
  assert_wake_masked_R4: assert property (@(posedge clk) disable iff (!por_n)
    (irq_en == '0) |-> !wake);

endmodule

// File: rtl/lpc_window_timer.sv
module lpc_window_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         expired
);

  logic [W-1:0] count_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                  count_q <= '0;
    else if (restart)            count_q <= '0;
    else if (count_q != {W{1'b1}}) count_q <= count_q + 1'b1;
  end

  assign expired = ({1'b0, count_q} + 1'b1) >= {1'b0, limit};

  // R10: a long reset hold saturates the count instead of wrapping.
  assert_timer_saturates_R10: assert property (@(posedge clk) disable iff (!por_n)
    (!restart && count_q == {W{1'b1}}) |=> (count_q == {W{1'b1}}));

endmodule

// File: rtl/lpc_mode_seq.sv
module lpc_mode_seq
  import lpc_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       hw_reset,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata,
  input  logic       wake,
  input  logic       tmr_expired,
  output lpc_state_e state_q,
  output logic       restart,
  output logic [1:0] mode_bits
);

  lpc_state_e state_d;
  logic [1:0] mode_q;
  logic       run_write;
  logic       idle_exit;

  assign run_write = (state_q == ST_RUN) && mode_wr && !hw_reset;
  assign idle_exit = (state_q == ST_IDLE) && (state_d == ST_RUN);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN: begin
        if (hw_reset)                          state_d = ST_RESET;
        else if (mode_wr && mode_wdata[MODE_PD_BIT])   state_d = ST_PDOWN;
        else if (mode_wr && mode_wdata[MODE_IDLE_BIT]) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (hw_reset)  state_d = ST_GRACE;
        else if (wake) state_d = ST_RUN;
      end
      ST_PDOWN: if (hw_reset) state_d = ST_RESET;
      ST_GRACE: if (tmr_expired) state_d = ST_RESET;
      ST_RESET: if (tmr_expired && !hw_reset) state_d = ST_RUN;
      default:  state_d = ST_RESET;
    endcase
  end

  assign restart = (state_d != state_q);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q <= ST_RESET;
      mode_q  <= 2'b00;
    end else begin
      state_q <= state_d;
      if ((state_d == ST_RESET) || idle_exit) mode_q <= 2'b00;
      else if (run_write)                     mode_q <= mode_wdata;
    end
  end

  assign mode_bits = mode_q;

  assert_pd_only_reset_exits_R5: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_PDOWN && !hw_reset) |=> (state_q == ST_PDOWN));

  assert_idle_wake_clears_R4: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_IDLE && wake && !hw_reset) |=> (state_q == ST_RUN && mode_bits == 2'b00));

  assert_pd_priority_R3: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_RUN && !hw_reset && mode_wr && mode_wdata[MODE_PD_BIT]) |=> (state_q == ST_PDOWN));

  assert_reset_beats_write_R9: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_RUN && hw_reset) |=> (state_q == ST_RESET && mode_bits == 2'b00));

endmodule

// File: rtl/lpc_power_ctrl.sv
module lpc_power_ctrl
  import lpc_pkg::*;
#(
  parameter int NIRQ           = 5,
  parameter int MC_CLKS        = 12,
  parameter int STARTUP_CYCLES = 64
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            hw_reset,
  input  logic            mode_wr,
  input  logic [1:0]      mode_wdata,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  output logic [1:0]      mode_bits,
  output logic            cpu_clk_en,
  output logic            periph_clk_en,
  output logic            osc_en,
  output logic            sfr_reset,
  output logic            ram_wr_inhibit
);

  localparam int GRACE = grace_cycles(MC_CLKS);
  localparam int TW    = timer_width(GRACE, STARTUP_CYCLES);
  localparam int OW    = $clog2(STARTUP_CYCLES + 1);

  lpc_state_e   state;
  lpc_outs_t    outs;
  logic         wake;
  logic         restart;
  logic         tmr_expired;
  logic [TW-1:0] limit;

  // Named events for the checks below.
  logic in_idle;
  logic in_grace;

  lpc_wake_detect #(.NIRQ(NIRQ)) wake_i (
    .clk     (clk),
    .por_n   (por_n),
    .irq_req (irq_req),
    .irq_en  (irq_en),
    .wake    (wake)
  );

  lpc_mode_seq seq_i (
    .clk         (clk),
    .por_n       (por_n),
    .hw_reset    (hw_reset),
    .mode_wr     (mode_wr),
    .mode_wdata  (mode_wdata),
    .wake        (wake),
    .tmr_expired (tmr_expired),
    .state_q     (state),
    .restart     (restart),
    .mode_bits   (mode_bits)
  );

  assign limit = (state == ST_GRACE) ? TW'(GRACE) : TW'(STARTUP_CYCLES);

  lpc_window_timer #(.W(TW)) timer_i (
    .clk     (clk),
    .por_n   (por_n),
    .restart (restart),
    .limit   (limit),
    .expired (tmr_expired)
  );

  assign outs           = decode_outputs(state);
  assign cpu_clk_en     = outs.cpu;
  assign periph_clk_en  = outs.periph;
  assign osc_en         = outs.osc;
  assign sfr_reset      = outs.sfr_rst;
  assign ram_wr_inhibit = outs.ram_inh;

  assign in_idle  = (state == ST_IDLE);
  assign in_grace = (state == ST_GRACE);

  // Cycles since the oscillator enable was last raised (saturating).
  logic [OW-1:0] osc_up_cnt;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                             osc_up_cnt <= '0;
    else if (!osc_en)                       osc_up_cnt <= '0;
    else if (osc_up_cnt < OW'(STARTUP_CYCLES)) osc_up_cnt <= osc_up_cnt + 1'b1;
  end

  assert_cpu_needs_osc_R3: assert property (@(posedge clk) disable iff (!por_n)
    !osc_en |-> !cpu_clk_en);

  assert_startup_gap_R8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cpu_clk_en) |-> (osc_up_cnt >= OW'(STARTUP_CYCLES)));

  assert_grace_window_R6: assert property (@(posedge clk) disable iff (!por_n)
    (in_idle && hw_reset) |=> (cpu_clk_en && ram_wr_inhibit && !sfr_reset && in_grace));

  assert_reset_keeps_ram_R7: assert property (@(posedge clk) disable iff (!por_n)
    sfr_reset |-> (ram_wr_inhibit && !cpu_clk_en));

endmodule

// File: tb/lpc_power_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpc_power_ctrl_tb_top;

  localparam int NIRQ = 5;
  localparam int MC   = 4;
  localparam int SU   = 10;
  localparam int GR   = 2 * MC;

  logic            clk = 1'b0;
  logic            por_n = 1'b0;
  logic            hw_reset = 1'b0;
  logic            mode_wr = 1'b0;
  logic [1:0]      mode_wdata = 2'b00;
  logic [NIRQ-1:0] irq_req = '0;
  logic [NIRQ-1:0] irq_en = '0;
  logic [1:0]      mode_bits;
  logic            cpu_clk_en, periph_clk_en, osc_en, sfr_reset, ram_wr_inhibit;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  lpc_power_ctrl #(.NIRQ(NIRQ), .MC_CLKS(MC), .STARTUP_CYCLES(SU)) dut_i (
    .clk(clk), .por_n(por_n), .hw_reset(hw_reset), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .irq_req(irq_req), .irq_en(irq_en),
    .mode_bits(mode_bits), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .osc_en(osc_en), .sfr_reset(sfr_reset), .ram_wr_inhibit(ram_wr_inhibit)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_val(input string req, input string what, input int act, input int exp);
    check(act == exp, req, what, act, exp);
  endtask

  // Outputs packed as {cpu, periph, osc, sfr, inh}.
  function automatic int outs_now();
    return {cpu_clk_en, periph_clk_en, osc_en, sfr_reset, ram_wr_inhibit};
  endfunction

  task automatic wait_cpu(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cpu_clk_en && n < 1000);
  endtask

  task automatic write_mode(input logic [1:0] v);
    @(negedge clk);
    mode_wr = 1'b1;
    mode_wdata = v;
    @(negedge clk);
    mode_wr = 1'b0;
    mode_wdata = 2'b00;
  endtask

  task automatic t_power_on();
    int n;
    por_n = 1'b0;
    repeat (3) @(negedge clk);
    check_val("R1", "reset outputs", outs_now(), 5'b01111);
    check_val("R1", "mode after power-on", mode_bits, 0);
    por_n = 1'b1;
    wait_cpu(n);
    check_val("R1", "start-up length", n, SU);
    check_val("R7", "run outputs", outs_now(), 5'b11100);
  endtask

  task automatic t_idle_irq();
    write_mode(2'b01);
    check_val("R2", "idle outputs", outs_now(), 5'b01100);
    check_val("R2", "idle mode bits", mode_bits, 1);
    irq_req = 5'b00100;
    irq_en  = 5'b00011;
    @(negedge clk);
    @(negedge clk);
    check_val("R4", "masked irq keeps idle", cpu_clk_en, 0);
    irq_en = 5'b00100;
    @(negedge clk);
    check_val("R4", "enabled irq wakes", cpu_clk_en, 1);
    check_val("R4", "mode cleared on wake", mode_bits, 0);
    irq_req = '0;
    irq_en  = '0;
  endtask

  task automatic t_write_in_idle();
    write_mode(2'b01);
    write_mode(2'b10);
    check_val("R9", "write in idle ignored (outputs)", outs_now(), 5'b01100);
    check_val("R9", "write in idle ignored (mode)", mode_bits, 1);
    irq_req = 5'b10000;
    irq_en  = 5'b10000;
    @(negedge clk);
    check_val("R4", "wake after ignored write", cpu_clk_en, 1);
    irq_req = '0;
    irq_en  = '0;
  endtask

  task automatic t_pdown();
    int n;
    write_mode(2'b11);
    check_val("R3", "power-down outputs", outs_now(), 5'b00000);
    check_val("R3", "power-down mode bits", mode_bits, 3);
    irq_req = 5'b11111;
    irq_en  = 5'b11111;
    repeat (4) @(negedge clk);
    check_val("R5", "irq ignored in power-down", outs_now(), 5'b00000);
    irq_req = '0;
    irq_en  = '0;
    hw_reset = 1'b1;
    @(negedge clk);
    check_val("R8", "oscillator back on reset", outs_now(), 5'b01111);
    check_val("R1", "mode cleared by reset", mode_bits, 0);
    hw_reset = 1'b0;
    wait_cpu(n);
    check_val("R8", "cpu hold after oscillator restart", n, SU);
  endtask

  task automatic t_idle_reset();
    int g;
    int s;
    bit inh_ok;
    write_mode(2'b01);
    hw_reset = 1'b1;
    @(negedge clk);
    hw_reset = 1'b0;
    g = 0;
    inh_ok = 1'b1;
    while (cpu_clk_en && !sfr_reset && g < 1000) begin
      if (!ram_wr_inhibit) inh_ok = 1'b0;
      g++;
      @(negedge clk);
    end
    check_val("R6", "grace window length", g, GR);
    check_val("R6", "RAM blocked in grace", inh_ok, 1);
    s = 0;
    inh_ok = 1'b1;
    while (sfr_reset && s < 1000) begin
      if (!ram_wr_inhibit || cpu_clk_en) inh_ok = 1'b0;
      s++;
      @(negedge clk);
    end
    check_val("R7", "reset phase after grace", s, SU);
    check_val("R7", "RAM blocked in reset phase", inh_ok, 1);
    check_val("R7", "run after grace reset", outs_now(), 5'b11100);
  endtask

  task automatic t_held_reset();
    int n;
    bit held_ok;
    @(negedge clk);
    hw_reset = 1'b1;
    mode_wr = 1'b1;
    mode_wdata = 2'b01;
    @(negedge clk);
    mode_wr = 1'b0;
    mode_wdata = 2'b00;
    check_val("R9", "reset beats mode write", outs_now(), 5'b01111);
    check_val("R9", "mode stays clear", mode_bits, 0);
    held_ok = 1'b1;
    repeat (3 * SU) begin
      @(negedge clk);
      if (!sfr_reset || cpu_clk_en) held_ok = 1'b0;
    end
    check_val("R10", "reset held while pin high", held_ok, 1);
    hw_reset = 1'b0;
    wait_cpu(n);
    check_val("R10", "cpu one cycle after release", n, 1);
  endtask

  initial begin
    t_power_on();
    t_idle_irq();
    t_write_in_idle();
    t_pdown();
    t_idle_reset();
    t_held_reset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule